// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small processor core under a fixed priority order. The highest source cannot be masked. Three sources have fixed internal vectors and per-source masks. The lowest source has no internal vector, so the core must fetch that vector from the requesting device. A global enable flag gates every maskable source. The core sets this flag with an enable command and clears it with a disable command.

The core pulses `boundary` at each instruction boundary. On that pulse the controller picks the highest-priority eligible request and registers it. It then holds `irq_req`, the vector and the external-vector flag steady until the core pulses `ack`. Accepting a maskable source drops the global enable. A mask-write command loads the three vectored masks from a byte and can also discard a latched edge. A status byte shows the pending vectored sources, the masks and the enable flag at all times.

The sources differ in how they are sensed. The non-maskable source needs a fresh rising edge, and its input must still be high when the boundary samples it. The second source latches a rising edge and keeps it pending. The remaining three sources are plain levels.

Top module: `prio_irq_ctrl`

## Requirements
- R1: At a boundary the granted source is the highest eligible one, in the order nmi_in, edge_in, lvl_hi_in, lvl_lo_in, ext_in.
- R2: The vectors are 0x0024 for nmi_in, 0x003C for edge_in, 0x0034 for lvl_hi_in and 0x002C for lvl_lo_in. A grant of ext_in gives vector 0x0000 with irq_ext=1. Every other grant has irq_ext=0.
- R3: nmi_in is granted whatever the enable flag and masks hold. It is granted only after a rising edge, and only while the input is still high at the boundary. Its latch is lost when the input falls, and it is consumed when the grant is acknowledged.
- R4: A rising edge on edge_in stays pending after the input falls. The pending bit is cleared when that source is acknowledged, or by a mask write with bit 4 set.
- R5: lvl_hi_in, lvl_lo_in and ext_in are not latched. A level that drops before the boundary is not granted.
- R6: en_cmd sets the enable flag and dis_cmd clears it. If both arrive in the same cycle, dis_cmd wins. While the flag is clear, only nmi_in can be granted.
- R7: Acknowledging a maskable grant clears the enable flag. Acknowledging an nmi_in grant leaves the flag unchanged.
- R8: On mask_wr with mask_data[3]=1, mask_data[2], mask_data[1] and mask_data[0] become the masks for edge_in, lvl_hi_in and lvl_lo_in. A 1 in a mask bit blocks that source. With mask_data[3]=0 the masks do not change.
- R9: status_out holds the masks (edge_in, lvl_hi_in, lvl_lo_in) in bits 2..0, the enable flag in bit 3, lvl_lo_in in bit 4, lvl_hi_in in bit 5, the edge_in pending bit in bit 6, and 0 in bit 7.
- R10: A grant appears in the cycle after the boundary and holds a stable vector until ack. A boundary seen while a grant is outstanding is ignored. With no boundary, nothing is granted.
- R11: After reset, irq_req is 0, the enable flag is 0, all three masks are 1, and status_out reads 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_in | input | 1 | Non-maskable request, edge and level sensed |
| edge_in | input | 1 | Maskable request, edge latched |
| lvl_hi_in | input | 1 | Maskable level request, middle priority |
| lvl_lo_in | input | 1 | Maskable level request, lower priority |
| ext_in | input | 1 | Maskable level request whose vector comes from outside |
| en_cmd | input | 1 | Set the global enable |
| dis_cmd | input | 1 | Clear the global enable |
| mask_wr | input | 1 | Mask-write strobe |
| mask_data | input | 8 | Mask-write value |
| boundary | input | 1 | Instruction boundary strobe |
| ack | input | 1 | Grant acknowledge |
| irq_req | output | 1 | Grant outstanding |
| irq_vec | output | 16 | Vector of the granted source |
| irq_ext | output | 1 | Vector must come from the external device |
| status_out | output | 8 | Pending, mask and enable status |

## Verification
The main sweep runs every combination of the five request lines, both enable states and all eight mask values. Priority, vector selection and the external flag are compared against a model in the bench, so one case that grants the wrong source or the wrong vector stands out from its neighbours. The sweep also checks the enable flag and the edge latch after each acknowledge, which shows whether an nmi_in grant and a maskable grant are treated differently. Directed sequences then cover the timing cases: a level that drops before the boundary, an nmi_in pulse that falls before sampling or is held across its own acknowledge, a boundary seen while a grant is outstanding, a mask write with bit 3 clear, and enable and disable commands arriving together.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_NMI  = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_EDGE = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_HI   = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_LO   = 16'h002C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_in,
  input  logic             edge_in,
  input  logic             lvl_hi_in,
  input  logic             lvl_lo_in,
  input  logic             ext_in,
  input  logic             en_cmd,
  input  logic             dis_cmd,
  input  logic             mask_wr,
  input  logic [7:0]       mask_data,
  input  logic             boundary,
  input  logic             ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_ext,
  output logic [7:0]       status_out
);

  localparam int NSRC = 5;
  localparam int S_NMI = 4, S_EDGE = 3, S_HI = 2, S_LO = 1, S_EXT = 0;

  logic            nmi_d, edge_d, nmi_q, edge_q, ie_q;
  logic [2:0]      mask_q;
  logic [NSRC-1:0] sel_q, cand, win;
  logic            nmi_pend, take, accept;

  assign nmi_pend = nmi_q & nmi_in;
  assign take     = boundary & ~irq_req;
  assign accept   = ack & irq_req;

  assign cand[S_NMI]  = nmi_pend;
  assign cand[S_EDGE] = ie_q & ~mask_q[2] & edge_q;
  assign cand[S_HI]   = ie_q & ~mask_q[1] & lvl_hi_in;
  assign cand[S_LO]   = ie_q & ~mask_q[0] & lvl_lo_in;
  assign cand[S_EXT]  = ie_q & ext_in;

  assign win[S_NMI]  = cand[S_NMI];
  assign win[S_EDGE] = cand[S_EDGE] & ~cand[S_NMI];
  assign win[S_HI]   = cand[S_HI]   & ~|cand[S_NMI:S_EDGE];
  assign win[S_LO]   = cand[S_LO]   & ~|cand[S_NMI:S_HI];
  assign win[S_EXT]  = cand[S_EXT]  & ~|cand[S_NMI:S_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d  <= 1'b0;
      edge_d <= 1'b0;
      nmi_q  <= 1'b0;
      edge_q <= 1'b0;
      ie_q   <= 1'b0;
      mask_q <= 3'b111;
      sel_q  <= '0;
    end else begin
      nmi_d  <= nmi_in;
      edge_d <= edge_in;

      if (!nmi_in || (accept && sel_q[S_NMI])) nmi_q <= 1'b0;
      else if (!nmi_d)                         nmi_q <= 1'b1;

      if (edge_in && !edge_d)                                    edge_q <= 1'b1;
      else if ((accept && sel_q[S_EDGE]) || (mask_wr && mask_data[4])) edge_q <= 1'b0;

      if (accept && !sel_q[S_NMI]) ie_q <= 1'b0;
      else if (dis_cmd)            ie_q <= 1'b0;
      else if (en_cmd)             ie_q <= 1'b1;

      if (mask_wr && mask_data[3]) mask_q <= mask_data[2:0];

      if (accept)    sel_q <= '0;
      else if (take) sel_q <= win;
    end
  end

  assign irq_req = |sel_q;
  assign irq_ext = sel_q[S_EXT];
  assign irq_vec = ({VEC_W{sel_q[S_NMI]}}  & VEC_NMI)
                 | ({VEC_W{sel_q[S_EDGE]}} & VEC_EDGE)
                 | ({VEC_W{sel_q[S_HI]}}   & VEC_HI)
                 | ({VEC_W{sel_q[S_LO]}}   & VEC_LO);
  assign status_out = {1'b0, edge_q, lvl_hi_in, lvl_lo_in, ie_q, mask_q};

  assert_nmi_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !irq_req && nmi_q && nmi_in) |=> (irq_req && irq_vec == VEC_NMI));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_ext)));
  assert_ext_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_ext == (irq_vec == '0)));
  assert_ie_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && irq_vec != VEC_NMI) |=> !status_out[3]);
  assert_dis_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_cmd && !en_cmd) |=> !status_out[3]);
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !irq_req && !status_out[3] && !(nmi_q && nmi_in)) |=> !irq_req);
  assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_in && !edge_d) |=> status_out[6]);
  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_data[3]) |=> (status_out[2:0] == $past(mask_data[2:0])));
  assert_no_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !boundary) |=> !irq_req);

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_in = 0, edge_in = 0, lvl_hi_in = 0, lvl_lo_in = 0, ext_in = 0;
  logic en_cmd = 0, dis_cmd = 0, mask_wr = 0, boundary = 0, ack = 0;
  logic [7:0] mask_data = 8'h00;
  logic irq_req, irq_ext;
  logic [15:0] irq_vec;
  logic [7:0] status_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic mwrite(input logic [7:0] d);
    mask_wr = 1; mask_data = d; step(); mask_wr = 0;
  endtask

  task automatic pulse_boundary();
    boundary = 1; step(); boundary = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; step(); ack = 0;
  endtask

  function automatic logic [15:0] vec_of(input int idx);
    case (idx)
      4: return 16'h0024;
      3: return 16'h003C;
      2: return 16'h0034;
      1: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step();
    rst_n = 1; step();
    check("R11 reset req", irq_req, 0);
    check("R11 reset status", status_out, 8'h07);

    for (int c = 0; c < 512; c++) begin
      logic [4:0] r; logic ie; logic [2:0] m; logic [4:0] cand; int w;
      r = c[4:0]; ie = c[5]; m = c[8:6];
      mwrite({3'b000, 2'b11, m});
      if (ie) en_cmd = 1; else dis_cmd = 1;
      step(); en_cmd = 0; dis_cmd = 0;
      nmi_in = r[4]; edge_in = r[3]; lvl_hi_in = r[2]; lvl_lo_in = r[1]; ext_in = r[0];
      step();
      pulse_boundary();
      cand = {r[4], ie & ~m[2] & r[3], ie & ~m[1] & r[2], ie & ~m[0] & r[1], ie & r[0]};
      w = -1;
      for (int k = 0; k < 5; k++) if (cand[k]) w = k;
      check("R1 grant", irq_req, w >= 0);
      if (w >= 0) begin
        check("R2 vector", irq_vec, vec_of(w));
        check("R2 ext flag", irq_ext, w == 0);
      end
      check("R9 status", status_out, {1'b0, r[3], r[2], r[1], ie, m});
      pulse_ack();
      check("R10 cleared by ack", irq_req, 0);
      check("R7 enable after ack", status_out[3], (w >= 1 && w <= 3) || w == 0 ? 1'b0 : ie);
      check("R4 edge after ack", status_out[6], (w == 3) ? 1'b0 : r[3]);
      nmi_in = 0; edge_in = 0; lvl_hi_in = 0; lvl_lo_in = 0; ext_in = 0;
      step();
    end

    mwrite(8'h18); en_cmd = 1; step(); en_cmd = 0;
    lvl_hi_in = 1; step(); lvl_hi_in = 0; step();
    pulse_boundary();
    check("R5 dropped level", irq_req, 0);

    nmi_in = 1; step(); nmi_in = 0; step(); nmi_in = 1; step();
    nmi_in = 0; step(); pulse_boundary();
    check("R3 nmi fell before boundary", irq_req, 0);

    nmi_in = 1; step(); pulse_boundary();
    check("R3 nmi vector", irq_vec, 16'h0024);
    pulse_ack();
    check("R7 nmi keeps enable", status_out[3], 1);
    pulse_boundary();
    check("R3 held nmi no regrant", irq_req, 0);
    nmi_in = 0; step();

    step(); pulse_boundary();
    check("R10 quiet boundary", irq_req, 0);
    lvl_lo_in = 1; step(); step();
    check("R10 no boundary no grant", irq_req, 0);
    pulse_boundary();
    check("R2 low vector", irq_vec, 16'h002C);
    nmi_in = 1; step(); pulse_boundary();
    check("R10 boundary ignored while pending", irq_vec, 16'h002C);
    pulse_ack(); nmi_in = 0; lvl_lo_in = 0; step();

    edge_in = 1; step(); edge_in = 0; step();
    check("R4 edge held", status_out[6], 1);
    mwrite(8'h10);
    check("R4 cleared by write bit4", status_out[6], 0);
    check("R8 masks kept", status_out[2:0], 3'b000);
    mwrite(8'h05);
    check("R8 write without bit3 ignored", status_out[2:0], 3'b000);

    en_cmd = 1; dis_cmd = 1; step(); en_cmd = 0; dis_cmd = 0;
    check("R6 disable wins", status_out[3], 0);
    ext_in = 1; step(); pulse_boundary();
    check("R6 disabled blocks", irq_req, 0);
    ext_in = 0; step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule